// File: doc/BRIEF.md
# Codec I2C Write Command Engine

This block is a write-only I2C master that sends short register updates to an audio codec. Software places a codec register index (7 bits) and a value (9 bits) in a command word, then writes a control word that carries a go bit, a final-transfer bit and the 7-bit device address. The engine then produces the whole transfer on SCL and SDA: a START condition, the device address with the write direction bit, and two payload bytes, sampling the acknowledge after each byte.

The go bit reads back as 1 for as long as the transfer is running and drops to 0 when it ends. If any byte is not acknowledged, the engine stops at once, issues a STOP condition and raises a sticky abort flag. Software can read that flag and reissue the transfer; a fixed retry budget is a software policy. SCL timing comes from a parameterised divider of the system clock. The engine drives SCL push-pull because clock stretching is not supported. SDA is open-drain: the engine only pulls it low or releases it.

Top module: `codec_i2c_writer`

## Requirements
- R1: After reset SCL is high, SDA is released, and the control word reads 0 (not busy, LAST clear, abort clear).
- R2: A command-word write (select 0) stores the register index from bits 31:25 and the value from bits 24:16. Reading select 0 returns those bits in place, with bits 15:0 as zero.
- R3: A control write (select 1) with bit 0 set, made while idle, launches a transfer. Control bit 0 reads 1 while the transfer runs and 0 once it has ended.
- R4: The wire sequence is a START condition, then {device address, 0}, then {register[6:0], value[8]}, then value[7:0]. Each byte is sent MSB first and is followed by one acknowledge clock. The device address sits in control bits 14:8.
- R5: With control bit 1 (LAST) set, a fully acknowledged transfer ends with a STOP condition. With it clear, the transfer ends with SCL held low, SDA released and no STOP, and the next transfer opens with a repeated START.
- R6: A NACK on any byte ends the transfer right after that acknowledge clock: no further byte is sent, a STOP is issued whatever LAST is, and abort (control bit 2) reads 1.
- R7: Abort stays set until the next launch, and a launch clears it.
- R8: SDA changes while SCL is high only to form a START condition (falling) or a STOP condition (rising).
- R9: Command and control writes made while a transfer is in flight are ignored. The bytes on the wire and the readback values stay those of the running transfer.
- R10: Each SCL high phase inside a transfer lasts 2 × QUARTER_CYCLES clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_sel | input | 1 | Register select: 0 command word, 1 control word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the select of the previous cycle |
| scl_o | output | 1 | I2C clock, driven push-pull |
| sda_pull_low_o | output | 1 | 1 pulls SDA low, 0 releases it |
| sda_i | input | 1 | Sensed SDA line level |

## Verification
Two things can overlap in time: a register write arriving while a transfer is in flight, and a NACK ending the transfer early. The bench tests the first by writing new command and control words just after a launch. It then confirms that the bytes the slave model captures, the command readback and the address readback all still belong to the original transfer. The second is provoked by having the slave model refuse a chosen byte, across random transfers. Each such transfer is judged on which bytes reached the wire, whether exactly one STOP followed, and how the abort flag behaved, including that a new launch clears it.

// File: rtl/codec_i2c_pkg.sv
package codec_i2c_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_START = 2'd1,
    ST_SHIFT = 2'd2,
    ST_STOP  = 2'd3
  } eng_state_t;

  localparam int CTRL_GO_BIT    = 0;
  localparam int CTRL_LAST_BIT  = 1;
  localparam int CTRL_ABORT_BIT = 2;
  localparam int CTRL_ADDR_LSB  = 8;
  localparam int DEV_ADDR_W     = 7;
  localparam int CMD_LSB        = 16;
  localparam int PAYLOAD_W      = 16;
  localparam int BUS_W          = 32;
endpackage

// File: rtl/codec_i2c_tick.sv
module codec_i2c_tick #(
  parameter int QUARTER_CYCLES = 125
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);
  localparam int CW = (QUARTER_CYCLES > 1) ? $clog2(QUARTER_CYCLES) : 1;
  localparam logic [CW-1:0] LIMIT = CW'(QUARTER_CYCLES - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else if (cnt == LIMIT) begin
      cnt  <= '0;
      tick <= 1'b1;
    end else begin
      cnt  <= cnt + 1'b1;
      tick <= 1'b0;
    end
  end

  generate
    if (QUARTER_CYCLES > 1) begin : g_spacing
      // R10: quarter ticks never come back to back
      assert_tick_spacing_R10: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick);
    end
  endgenerate
endmodule

// File: rtl/codec_i2c_regs.sv
module codec_i2c_regs
  import codec_i2c_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  bus_wr,
  input  logic                  bus_sel,
  input  logic [BUS_W-1:0]      bus_wdata,
  output logic [BUS_W-1:0]      bus_rdata,
  input  logic                  done_i,
  input  logic                  nack_i,
  output logic                  launch_o,
  output logic                  last_o,
  output logic [DEV_ADDR_W-1:0] addr_o,
  output logic [PAYLOAD_W-1:0]  payload_o
);
  logic                  busy_q, abort_q, last_q;
  logic [DEV_ADDR_W-1:0] addr_q;
  logic [PAYLOAD_W-1:0]  cmd_q;
  logic                  go_req;
  logic [BUS_W-1:0]      ctrl_word;
  logic                  unused_wdata_bits;

  assign unused_wdata_bits = ^{bus_wdata[BUS_W-1:CTRL_ADDR_LSB+DEV_ADDR_W],
                               bus_wdata[CTRL_ADDR_LSB-1:CTRL_ABORT_BIT]};

  assign go_req = bus_wr && bus_sel && bus_wdata[CTRL_GO_BIT] && !busy_q;

  always_comb begin
    ctrl_word = '0;
    ctrl_word[CTRL_GO_BIT]    = busy_q;
    ctrl_word[CTRL_LAST_BIT]  = last_q;
    ctrl_word[CTRL_ABORT_BIT] = abort_q;
    ctrl_word[CTRL_ADDR_LSB +: DEV_ADDR_W] = addr_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q    <= 1'b0;
      abort_q   <= 1'b0;
      last_q    <= 1'b0;
      addr_q    <= '0;
      cmd_q     <= '0;
      launch_o  <= 1'b0;
      bus_rdata <= '0;
    end else begin
      launch_o <= go_req;
      if (bus_wr && !bus_sel && !busy_q)
        cmd_q <= bus_wdata[CMD_LSB +: PAYLOAD_W];
      if (go_req) begin
        busy_q  <= 1'b1;
        abort_q <= 1'b0;
        last_q  <= bus_wdata[CTRL_LAST_BIT];
        addr_q  <= bus_wdata[CTRL_ADDR_LSB +: DEV_ADDR_W];
      end else if (done_i) begin
        busy_q <= 1'b0;
        if (nack_i) abort_q <= 1'b1;
      end
      bus_rdata <= bus_sel ? ctrl_word : {cmd_q, {CMD_LSB{1'b0}}};
    end
  end

  assign last_o    = last_q;
  assign addr_o    = addr_q;
  assign payload_o = cmd_q;

  // R3: busy only ends when the engine reports completion
  assert_busy_ends_on_done_R3: assert property (@(posedge clk) disable iff (rst)
    $fell(busy_q) |-> $past(done_i));
  // R6: abort only rises on a completion that carried a NACK
  assert_abort_only_on_nack_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(abort_q) |-> $past(done_i && nack_i));
  // R7: abort only clears together with a launch
  assert_abort_clears_on_launch_R7: assert property (@(posedge clk) disable iff (rst)
    $fell(abort_q) |-> launch_o);
  // R9: the command word is frozen during a transfer
  assert_cmd_frozen_R9: assert property (@(posedge clk) disable iff (rst)
    (busy_q && $past(busy_q)) |-> $stable(cmd_q));
endmodule

// File: rtl/codec_i2c_engine.sv
module codec_i2c_engine
  import codec_i2c_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  tick,
  input  logic                  launch_i,
  input  logic                  last_i,
  input  logic [DEV_ADDR_W-1:0] addr_i,
  input  logic [PAYLOAD_W-1:0]  payload_i,
  input  logic                  sda_i,
  output logic                  scl_o,
  output logic                  sda_low_o,
  output logic                  done_o,
  output logic                  nack_o
);
  localparam int FRAME_W = DEV_ADDR_W + 1 + PAYLOAD_W;
  localparam int NBYTES  = FRAME_W / 8;
  localparam logic [3:0] ACK_SLOT  = 4'd8;
  localparam logic [1:0] LAST_BYTE = 2'(NBYTES - 1);

  eng_state_t         st_q, st_n;
  logic [1:0]         q_q, q_n, byte_q, byte_n;
  logic [3:0]         bit_q, bit_n;
  logic               nack_q, nack_n, done_n, last_q;
  logic               scl_n, sdl_n;
  logic [FRAME_W-1:0] frame_q, frame_shift;
  logic [4:0]         idx;

  always_comb begin
    st_n   = st_q;
    q_n    = q_q;
    bit_n  = bit_q;
    byte_n = byte_q;
    nack_n = nack_q;
    done_n = 1'b0;
    if (st_q == ST_IDLE) begin
      if (launch_i) begin
        st_n   = ST_START;
        q_n    = 2'd0;
        nack_n = 1'b0;
      end
    end else if (tick) begin
      q_n = q_q + 2'd1;
      unique case (st_q)
        ST_START: if (q_q == 2'd3) begin
          st_n   = ST_SHIFT;
          bit_n  = 4'd0;
          byte_n = 2'd0;
        end
        ST_SHIFT: begin
          if (q_q == 2'd1 && bit_q == ACK_SLOT) nack_n = sda_i;
          if (q_q == 2'd3) begin
            if (bit_q != ACK_SLOT) bit_n = bit_q + 4'd1;
            else if (nack_q) st_n = ST_STOP;
            else if (byte_q == LAST_BYTE) begin
              if (last_q) st_n = ST_STOP;
              else begin
                st_n   = ST_IDLE;
                done_n = 1'b1;
              end
            end else begin
              byte_n = byte_q + 2'd1;
              bit_n  = 4'd0;
            end
          end
        end
        ST_STOP: if (q_q == 2'd3) begin
          st_n   = ST_IDLE;
          done_n = 1'b1;
        end
        default: ;
      endcase
    end
  end

  assign idx         = {byte_n, 3'b000} + {1'b0, bit_n};
  assign frame_shift = frame_q << idx;

  always_comb begin
    scl_n = scl_o;
    sdl_n = sda_low_o;
    unique case (st_n)
      ST_START: begin
        scl_n = (q_n == 2'd1) || (q_n == 2'd2);
        sdl_n = q_n[1];
      end
      ST_SHIFT: begin
        scl_n = (q_n == 2'd1) || (q_n == 2'd2);
        sdl_n = (bit_n == ACK_SLOT) ? 1'b0 : !frame_shift[FRAME_W-1];
      end
      ST_STOP: begin
        scl_n = (q_n != 2'd0);
        sdl_n = !q_n[1];
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q      <= ST_IDLE;
      q_q       <= '0;
      bit_q     <= '0;
      byte_q    <= '0;
      nack_q    <= 1'b0;
      last_q    <= 1'b0;
      frame_q   <= '0;
      done_o    <= 1'b0;
      scl_o     <= 1'b1;
      sda_low_o <= 1'b0;
    end else begin
      st_q      <= st_n;
      q_q       <= q_n;
      bit_q     <= bit_n;
      byte_q    <= byte_n;
      nack_q    <= nack_n;
      done_o    <= done_n;
      scl_o     <= scl_n;
      sda_low_o <= sdl_n;
      if (st_q == ST_IDLE && launch_i) begin
        last_q  <= last_i;
        frame_q <= {addr_i, 1'b0, payload_i};
      end
    end
  end

  assign nack_o = nack_q;

  // R8: SDA only moves under a high SCL while forming START or STOP
  assert_sda_moves_low_scl_R8: assert property (@(posedge clk) disable iff (rst)
    (scl_o && $past(scl_o) && !$stable(sda_low_o)) |-> (st_q == ST_START || st_q == ST_STOP));
  // R3: a launch is only handed over while the engine is idle
  assert_launch_when_idle_R3: assert property (@(posedge clk) disable iff (rst)
    launch_i |-> st_q == ST_IDLE);
  // R5: the completion pulse coincides with the idle state
  assert_done_in_idle_R5: assert property (@(posedge clk) disable iff (rst)
    done_o |-> st_q == ST_IDLE);
  // R6: a NACK never lets shifting continue past the acknowledge slot
  assert_nack_stops_shift_R6: assert property (@(posedge clk) disable iff (rst)
    (nack_q && st_q == ST_SHIFT) |-> bit_q == ACK_SLOT);
endmodule

// File: rtl/codec_i2c_writer.sv
module codec_i2c_writer
  import codec_i2c_pkg::*;
#(
  parameter int QUARTER_CYCLES = 125
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        bus_wr,
  input  logic        bus_sel,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        scl_o,
  output logic        sda_pull_low_o,
  input  logic        sda_i
);
  logic                  tick, launch, last, done, nack;
  logic [DEV_ADDR_W-1:0] addr;
  logic [PAYLOAD_W-1:0]  payload;

  codec_i2c_tick #(.QUARTER_CYCLES(QUARTER_CYCLES)) u_tick (
    .clk  (clk),
    .rst  (rst),
    .tick (tick)
  );

  codec_i2c_regs u_regs (
    .clk       (clk),
    .rst       (rst),
    .bus_wr    (bus_wr),
    .bus_sel   (bus_sel),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .done_i    (done),
    .nack_i    (nack),
    .launch_o  (launch),
    .last_o    (last),
    .addr_o    (addr),
    .payload_o (payload)
  );

  codec_i2c_engine u_engine (
    .clk       (clk),
    .rst       (rst),
    .tick      (tick),
    .launch_i  (launch),
    .last_i    (last),
    .addr_i    (addr),
    .payload_i (payload),
    .sda_i     (sda_i),
    .scl_o     (scl_o),
    .sda_low_o (sda_pull_low_o),
    .done_o    (done),
    .nack_o    (nack)
  );
endmodule

// File: tb/test_codec_i2c_writer.sv
module test_codec_i2c_writer;
  localparam int CLK_PERIOD = 10;
  localparam int QC = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0;
  logic        bus_sel = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        scl_line, sda_low;
  logic        slave_pull = 1'b0;
  wire         sda_line = ~(sda_low | slave_pull);

  int n_checks = 0;
  int n_fail = 0;

  codec_i2c_writer #(.QUARTER_CYCLES(QC)) i_codec_i2c_writer (
    .clk            (clk),
    .rst            (rst),
    .bus_wr         (bus_wr),
    .bus_sel        (bus_sel),
    .bus_wdata      (bus_wdata),
    .bus_rdata      (bus_rdata),
    .scl_o          (scl_line),
    .sda_pull_low_o (sda_low),
    .sda_i          (sda_line)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // slave model
  logic [7:0] sh = '0;
  logic [7:0] got [0:3];
  int bitcnt = 0, bytecnt = 0, nbytes = 0, nack_idx = 3;
  int starts = 0, stops = 0, hi_changes = 0;
  logic in_ack = 1'b0, active = 1'b0;
  time t_rise = 0, last_hi = 0;

  always @(negedge sda_line) if (scl_line === 1'b1) begin
    starts++; active = 1'b1; bitcnt = 0; bytecnt = 0; nbytes = 0;
    in_ack = 1'b0; slave_pull = 1'b0;
  end
  always @(posedge sda_line) if (scl_line === 1'b1) begin
    stops++; active = 1'b0;
  end
  always @(sda_line) if (scl_line === 1'b1) hi_changes++;
  always @(posedge scl_line) begin
    t_rise = $time;
    if (active && !in_ack && bitcnt < 8) begin
      sh = {sh[6:0], sda_line};
      bitcnt++;
      if (bitcnt == 8 && bytecnt < 4) begin
        got[bytecnt] = sh;
        nbytes++;
      end
    end
  end
  always @(negedge scl_line) begin
    if (scl_line === 1'b0) last_hi = $time - t_rise;
    if (active) begin
      if (in_ack) begin
        in_ack = 1'b0; slave_pull = 1'b0; bitcnt = 0; bytecnt++;
      end else if (bitcnt == 8) begin
        in_ack = 1'b1; slave_pull = (bytecnt != nack_idx);
      end
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic sel, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_sel = sel; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic sel, output logic [31:0] d);
    @(negedge clk);
    bus_sel = sel;
    @(negedge clk);
    d = bus_rdata;
  endtask

  function automatic logic [31:0] ctrl_val(input logic [6:0] a, input logic last);
    return (32'(a) << 8) | (32'(last) << 1) | 32'd1;
  endfunction

  function automatic logic [7:0] exp_byte(input int k, input logic [6:0] a,
                                          input logic [6:0] r, input logic [8:0] v);
    if (k == 0) return {a, 1'b0};
    if (k == 1) return {r, v[8]};
    return v[7:0];
  endfunction

  task automatic wait_idle(output logic [31:0] d);
    for (int i = 0; i < 5000; i++) begin
      rd(1'b1, d);
      if (d[0] == 1'b0) break;
    end
  endtask

  task automatic run_xfer(input logic [6:0] a, input logic [6:0] r, input logic [8:0] v,
                          input logic last, input int nk, input bit disturb);
    logic [31:0] d;
    int s0, p0, h0, exp_n, exp_stop;
    nack_idx = nk;
    s0 = starts; p0 = stops; h0 = hi_changes;
    wr(1'b0, {r, v, 16'h0000});
    wr(1'b1, ctrl_val(a, last));
    rd(1'b1, d);
    chk(d[0] == 1'b1, "R3 busy after launch", d, 32'h1);
    chk(d[2] == 1'b0, "R7 abort cleared by launch", d, 32'h0);
    if (disturb) begin
      wr(1'b0, ~{r, v, 16'h0000});
      wr(1'b1, ctrl_val(~a, ~last));
    end
    wait_idle(d);
    chk(d[0] == 1'b0, "R3 busy dropped", d, 32'h0);
    chk(d[2] == (nk < 3), "R6 abort flag", d, 32'(nk < 3));
    if (disturb) begin
      chk(d[14:8] == a, "R9 address readback", 32'(d[14:8]), 32'(a));
      rd(1'b0, d);
      chk(d == {r, v, 16'h0000}, "R9 command readback", d, {r, v, 16'h0000});
    end
    exp_n = (nk < 3) ? nk + 1 : 3;
    chk(nbytes == exp_n, "R6 byte count", 32'(nbytes), 32'(exp_n));
    for (int k = 0; k < exp_n; k++)
      chk(got[k] == exp_byte(k, a, r, v), "R4 byte on wire", 32'(got[k]), 32'(exp_byte(k, a, r, v)));
    exp_stop = (last || nk < 3) ? 1 : 0;
    chk(starts - s0 == 1, "R4 start count", 32'(starts - s0), 32'h1);
    chk(stops - p0 == exp_stop, "R5 stop count", 32'(stops - p0), 32'(exp_stop));
    chk(hi_changes - h0 == 1 + exp_stop, "R8 sda changes under high scl",
        32'(hi_changes - h0), 32'(1 + exp_stop));
    chk(last_hi == time'(2*QC*CLK_PERIOD), "R10 scl high width",
        32'(last_hi), 32'(2*QC*CLK_PERIOD));
    if (exp_stop == 0)
      chk(scl_line == 1'b0 && sda_line == 1'b1, "R5 bus held without stop",
          {30'b0, scl_line, sda_line}, 32'h1);
    else
      chk(scl_line == 1'b1 && sda_line == 1'b1, "R5 bus free after stop",
          {30'b0, scl_line, sda_line}, 32'h3);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] d;
    int r;
    void'($urandom(32'd4711));
    repeat (4) @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    chk(scl_line == 1'b1 && sda_line == 1'b1, "R1 idle lines", {30'b0, scl_line, sda_line}, 32'h3);
    rd(1'b1, d);
    chk(d == 32'h0, "R1 control after reset", d, 32'h0);
    // R2: command word placement
    wr(1'b0, {7'h55, 9'h1A3, 16'hFFFF});
    rd(1'b0, d);
    chk(d == {7'h55, 9'h1A3, 16'h0000}, "R2 command readback", d, {7'h55, 9'h1A3, 16'h0000});
    // directed corners
    run_xfer(7'h1A, 7'h7F, 9'h1FF, 1'b1, 3, 1'b0);
    run_xfer(7'h1A, 7'h00, 9'h000, 1'b1, 0, 1'b0);   // R6 NACK on address
    run_xfer(7'h1A, 7'h0C, 9'h155, 1'b0, 1, 1'b0);   // R6 NACK on byte 1, LAST clear
    run_xfer(7'h1A, 7'h0C, 9'h0AA, 1'b0, 3, 1'b0);   // R5 no stop, bus held
    run_xfer(7'h2B, 7'h33, 9'h123, 1'b1, 3, 1'b0);   // R5 repeated start
    run_xfer(7'h2B, 7'h41, 9'h0F0, 1'b1, 2, 1'b1);   // R9 writes in flight, R6 NACK last
    run_xfer(7'h2B, 7'h41, 9'h10F, 1'b0, 3, 1'b1);   // R9 with LAST clear
    // random mix
    for (int i = 0; i < 24; i++) begin
      r = int'($urandom % 6);
      run_xfer(7'($urandom), 7'($urandom), 9'($urandom), 1'($urandom % 4 != 0),
               (r < 3) ? r : 3, 1'($urandom % 3 == 0));
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule